// File: doc/BRIEF.md
# Serial Path-Overhead Fetch Port

This block sits on the transmit side of a high-order path processor. It fetches path-overhead bytes one at a time from an external source over a narrow serial link. A request names a VC and an overhead byte. If the port accepts it, the port sends an 8-bit byte address serially under an address strobe. It then leaves one idle step and raises a data strobe while it shifts in 8 data bits. The assembled byte is handed to the overhead inserter with a one-cycle valid flag.

The serial link steps at the rate of a clock-enable input. This lets the pins run slower than the core clock. Some requests are refused with a one-cycle error pulse and never reach the pins. These are the trace and signal-label bytes, undefined byte codes, VCs outside the frame, and VCs that are not the master of a concatenated group. A byte fetched for the path parity position is not inserted as it is. The port XORs it onto the locally computed BIP-8 and returns the result as an error-injected parity byte.

Top module: `poh_serial_port`

## Requirements
- R1: After an accepted start, `ale_o` is high for exactly 8 serial steps. During those steps `sao_o` carries the address {vc_i[3:0], idx_i[3:0]}, most significant bit first, one bit per step.
- R2: Exactly one serial step with both `ale_o` and `dle_o` low follows the address phase. `busy_o` stays high during that step.
- R3: `dle_o` is high for exactly 8 serial steps. `sdi_i` is sampled in each of them, and the first sample is the most significant bit of the byte. `ale_o` and `dle_o` are never high together.
- R4: A serial step takes place only on a clock cycle with `tick_i` high, and the pins hold still otherwise. With `tick_i` held high, `busy_o` is high for exactly 17 cycles, starting the cycle after the accepting edge.
- R5: `byte_vld_o` is a one-cycle pulse in the cycle after the last data bit is sampled. It comes with `byte_o`, and with `byte_vc_o` and `byte_idx_o` equal to the request.
- R6: For byte code 1 (path parity), `byte_o` is the fetched byte XOR `bip_i`, and `byte_mask_o` is high. For codes 3 to 8 the fetched byte is passed unchanged and `byte_mask_o` is low.
- R7: A start with byte code 0 (trace), code 2 (signal label), a code of 9 to 15, or a VC of 12 or more is refused. `err_o` pulses for one cycle and no strobe is raised.
- R8: `conc_mode_i` restricts which VCs are accepted. Mode 0 accepts VCs 0 to 11. Mode 1 accepts only 0, 3, 6 and 9. Mode 2 accepts only 0. Mode 3 refuses every request. A refusal behaves as in R7.
- R9: A start raised while `busy_o` is high is ignored. It raises no error, and the running transfer completes with its own address and data.
- R10: While reset is asserted, the port is idle: both strobes are low, `sao_o` is 0, and `busy_o`, `err_o` and `byte_vld_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a byte fetch |
| vc_i | input | 4 | VC index of the request |
| idx_i | input | 4 | Overhead byte code of the request |
| conc_mode_i | input | 2 | Concatenation mode: 0 none, 1 groups of 3, 2 single group of 12, 3 refuse all |
| bip_i | input | 8 | Locally computed parity byte, used for code 1 |
| tick_i | input | 1 | Serial step enable |
| sdi_i | input | 1 | Serial data in |
| ale_o | output | 1 | Address strobe |
| sao_o | output | 1 | Serial address out |
| dle_o | output | 1 | Data strobe |
| busy_o | output | 1 | Transfer in progress |
| err_o | output | 1 | Request refused (one-cycle pulse) |
| byte_o | output | 8 | Assembled byte |
| byte_vld_o | output | 1 | Byte valid (one-cycle pulse) |
| byte_vc_o | output | 4 | VC the byte belongs to |
| byte_idx_o | output | 4 | Byte code the byte belongs to |
| byte_mask_o | output | 1 | Byte is parity with the fetched mask applied |

## Verification
A wrong bit counter shows at the pins within the transfer: a strobe stays high for too few or too many steps, or the gap step is missing or doubled. The address bits seen under the address strobe are also shifted. A wrong phase register, or a wrong data-register alignment, corrupts `byte_o` on the very valid pulse of that transfer. A wrong admission decision shows in the cycle after the start: either `err_o` pulses on a legal request, or a strobe appears on a refused one. Random stalls on `tick_i` show whether any state moves without its enable, because the captured address and data then come out shifted.

// File: rtl/poh_pkg.sv
package poh_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_GAP, PH_DATA} phase_e;
  typedef enum logic [1:0] {CONC_NONE, CONC_GRP3, CONC_GRP12, CONC_RSVD} conc_e;

  localparam int unsigned IDX_TRACE = 0;
  localparam int unsigned IDX_PAR   = 1;
  localparam int unsigned IDX_LABEL = 2;
  localparam int unsigned IDX_LAST  = 8;
endpackage

// File: rtl/poh_req_check.sv
module poh_req_check
  import poh_pkg::*;
#(
  parameter int unsigned NUM_VC    = 12,
  parameter int unsigned VC_W      = 4,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned GRP_SMALL = 3
) (
  input  logic [VC_W-1:0]  vc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       conc_mode_i,
  output logic             ok_o,
  output logic             mask_o
);
  logic idx_ok, vc_ok, master_ok;
  conc_e mode;

  assign mode = conc_e'(conc_mode_i);

  always_comb begin
    idx_ok = (int'(idx_i) <= int'(IDX_LAST)) &&
             (int'(idx_i) != int'(IDX_TRACE)) &&
             (int'(idx_i) != int'(IDX_LABEL));
    vc_ok  = int'(vc_i) < int'(NUM_VC);
    unique case (mode)
      CONC_NONE:  master_ok = 1'b1;
      CONC_GRP3:  master_ok = (int'(vc_i) % int'(GRP_SMALL)) == 0;
      CONC_GRP12: master_ok = (vc_i == '0);
      default:    master_ok = 1'b0;
    endcase
  end

  assign ok_o   = idx_ok && vc_ok && master_ok;
  assign mask_o = int'(idx_i) == int'(IDX_PAR);
endmodule

// File: rtl/poh_shift_fsm.sv
module poh_shift_fsm
  import poh_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [AW-1:0] addr_i,
  input  logic          tick_i,
  input  logic          sdi_i,
  output logic          ale_o,
  output logic          sao_o,
  output logic          dle_o,
  output logic          busy_o,
  output logic          last_o,
  output logic [DW-1:0] word_o
);
  localparam int unsigned MAXW = (AW > DW) ? AW : DW;
  localparam int unsigned CW   = (MAXW > 1) ? $clog2(MAXW) : 1;

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] ash_q;
  logic [DW-1:0] dsh_q;

  assign ale_o  = (phase_q == PH_ADDR);
  assign dle_o  = (phase_q == PH_DATA);
  assign sao_o  = ale_o & ash_q[AW-1];
  assign busy_o = (phase_q != PH_IDLE);
  assign last_o = dle_o && tick_i && (cnt_q == CW'(DW-1));
  assign word_o = {dsh_q[DW-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ash_q   <= '0;
      dsh_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (launch_i) begin
          ash_q   <= addr_i;
          cnt_q   <= '0;
          phase_q <= PH_ADDR;
        end
        PH_ADDR: if (tick_i) begin
          ash_q <= {ash_q[AW-2:0], 1'b0};
          if (cnt_q == CW'(AW-1)) begin
            cnt_q   <= '0;
            phase_q <= PH_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_GAP: if (tick_i) begin
          cnt_q   <= '0;
          phase_q <= PH_DATA;
        end
        PH_DATA: if (tick_i) begin
          dsh_q <= word_o;
          if (last_o) begin
            cnt_q   <= '0;
            phase_q <= PH_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && dle_o)); // R3
  AST_GAP_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> (!dle_o && busy_o)); // R2
  AST_DATA_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dle_o) |-> !$past(ale_o)); // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> ($stable(ale_o) && $stable(dle_o) && $stable(sao_o))); // R4
endmodule

// File: rtl/poh_byte_out.sv
module poh_byte_out #(
  parameter int unsigned DW    = 8,
  parameter int unsigned VC_W  = 4,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             last_i,
  input  logic [DW-1:0]    word_i,
  input  logic             mask_i,
  input  logic [DW-1:0]    bip_i,
  input  logic [VC_W-1:0]  vc_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [DW-1:0]    byte_o,
  output logic             vld_o,
  output logic [VC_W-1:0]  vc_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      vld_o  <= 1'b0;
      vc_o   <= '0;
      idx_o  <= '0;
      mask_o <= 1'b0;
    end else begin
      vld_o <= last_i;
      if (last_i) begin
        byte_o <= mask_i ? (word_i ^ bip_i) : word_i;
        vc_o   <= vc_i;
        idx_o  <= idx_i;
        mask_o <= mask_i;
      end
    end
  end

  AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R5
endmodule

// File: rtl/poh_serial_port.sv
module poh_serial_port
  import poh_pkg::*;
#(
  parameter int unsigned NUM_VC    = 12,
  parameter int unsigned VC_W      = 4,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned DW        = 8,
  parameter int unsigned GRP_SMALL = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [VC_W-1:0]  vc_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       conc_mode_i,
  input  logic [DW-1:0]    bip_i,
  input  logic             tick_i,
  input  logic             sdi_i,
  output logic             ale_o,
  output logic             sao_o,
  output logic             dle_o,
  output logic             busy_o,
  output logic             err_o,
  output logic [DW-1:0]    byte_o,
  output logic             byte_vld_o,
  output logic [VC_W-1:0]  byte_vc_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             byte_mask_o
);
  localparam int unsigned AW = VC_W + IDX_W;

  logic             req_ok, req_mask, launch, last;
  logic [DW-1:0]    word;
  logic [VC_W-1:0]  vc_q;
  logic [IDX_W-1:0] idx_q;
  logic             mask_q;

  poh_req_check #(
    .NUM_VC(NUM_VC), .VC_W(VC_W), .IDX_W(IDX_W), .GRP_SMALL(GRP_SMALL)
  ) u_check (
    .vc_i(vc_i), .idx_i(idx_i), .conc_mode_i(conc_mode_i),
    .ok_o(req_ok), .mask_o(req_mask)
  );

  assign launch = start_i && !busy_o && req_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vc_q   <= '0;
      idx_q  <= '0;
      mask_q <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      err_o <= start_i && !busy_o && !req_ok;
      if (launch) begin
        vc_q   <= vc_i;
        idx_q  <= idx_i;
        mask_q <= req_mask;
      end
    end
  end

  poh_shift_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .addr_i({vc_i, idx_i}),
    .tick_i(tick_i), .sdi_i(sdi_i), .ale_o(ale_o), .sao_o(sao_o),
    .dle_o(dle_o), .busy_o(busy_o), .last_o(last), .word_o(word)
  );

  poh_byte_out #(.DW(DW), .VC_W(VC_W), .IDX_W(IDX_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .last_i(last), .word_i(word),
    .mask_i(mask_q), .bip_i(bip_i), .vc_i(vc_q), .idx_i(idx_q),
    .byte_o(byte_o), .vld_o(byte_vld_o), .vc_o(byte_vc_o),
    .idx_o(byte_idx_o), .mask_o(byte_mask_o)
  );

  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R7
  AST_ERR_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!ale_o && !busy_o)); // R7
  AST_BUSY_START_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> !err_o); // R9
  AST_VLD_AFTER_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> ($past(dle_o) && !busy_o)); // R5
endmodule

// File: tb/tb_poh_serial_port.sv
`timescale 1ns/1ps
module tb_poh_serial_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] vc_i = '0;
  logic [3:0] idx_i = '0;
  logic [1:0] conc_mode_i = '0;
  logic [7:0] bip_i = '0;
  logic       tick_i = 1'b0;
  logic       sdi_i = 1'b0;
  logic       ale_o, sao_o, dle_o, busy_o, err_o, byte_vld_o, byte_mask_o;
  logic [7:0] byte_o;
  logic [3:0] byte_vc_o, byte_idx_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  poh_serial_port dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .vc_i(vc_i), .idx_i(idx_i),
    .conc_mode_i(conc_mode_i), .bip_i(bip_i), .tick_i(tick_i), .sdi_i(sdi_i),
    .ale_o(ale_o), .sao_o(sao_o), .dle_o(dle_o), .busy_o(busy_o), .err_o(err_o),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .byte_vc_o(byte_vc_o),
    .byte_idx_o(byte_idx_o), .byte_mask_o(byte_mask_o)
  );

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_rej(input logic [3:0] vc, input logic [3:0] idx,
                                 input logic [1:0] mode);
    bit bad_idx = (idx == 0) || (idx == 2) || (idx > 8);
    bit bad_vc  = (vc >= 12);
    bit bad_m;
    case (mode)
      2'd0: bad_m = 0;
      2'd1: bad_m = (vc % 3) != 0;
      2'd2: bad_m = vc != 0;
      default: bad_m = 1;
    endcase
    return bad_idx || bad_vc || bad_m;
  endfunction

  function automatic logic [7:0] exp_byte(input logic [3:0] idx, input logic [7:0] d,
                                          input logic [7:0] bip);
    return (idx == 1) ? (d ^ bip) : d;
  endfunction

  // Called at a negedge; returns at a negedge with the port idle.
  task automatic run_txn(input logic [3:0] vc, input logic [3:0] idx, input logic [1:0] mode,
                         input logic [7:0] data, input logic [7:0] bip,
                         input bit full, input bit poke);
    bit rej = exp_rej(vc, idx, mode);
    logic [7:0] abits = '0;
    int an = 0, dn = 0, gn = 0, bn = 0, guard = 0;
    bit done = 0;
    vc_i = vc; idx_i = idx; conc_mode_i = mode; bip_i = bip;
    start_i = 1'b1;
    tick_i = full ? 1'b1 : 1'($urandom % 2);
    @(negedge clk_i);
    start_i = 1'b0;
    if (rej) begin
      chk(err_o === 1'b1, "R7/R8 err pulse", err_o, 1);
      chk(busy_o === 1'b0 && ale_o === 1'b0, "R7/R8 no strobe", {busy_o, ale_o}, 0);
      @(negedge clk_i);
      chk(err_o === 1'b0 && ale_o === 1'b0, "R7 err one cycle", {err_o, ale_o}, 0);
      return;
    end
    chk(err_o === 1'b0, "R8 legal accepted", err_o, 0);
    while (!done) begin
      if (byte_vld_o) begin
        done = 1;
        start_i = 1'b0;
        chk(an == 8, "R1 addr steps", an, 8);
        chk(abits == {vc, idx}, "R1 addr bits", abits, {vc, idx});
        chk(gn == 1, "R2 gap steps", gn, 1);
        chk(dn == 8, "R3 data steps", dn, 8);
        chk(byte_o == exp_byte(idx, data, bip), "R5/R6 byte", byte_o, exp_byte(idx, data, bip));
        chk(byte_mask_o == (idx == 1), "R6 mask flag", byte_mask_o, (idx == 1));
        chk(byte_vc_o == vc && byte_idx_o == idx, "R5 tag", {byte_vc_o, byte_idx_o}, {vc, idx});
        if (full) chk(bn == 17, "R4 busy length", bn, 17);
      end else begin
        bit t;
        if (ale_o && dle_o) chk(0, "R3 strobes exclusive", 1, 0);
        if (err_o) chk(0, "R9 no err while busy", 1, 0);
        if (busy_o) bn++;
        t = full ? 1'b1 : 1'(($urandom % 4) != 0);
        if (ale_o && t) begin abits = {abits[6:0], sao_o}; an++; end
        else if (dle_o && t) begin sdi_i = (dn < 8) ? data[7 - dn] : 1'b0; dn++; end
        else if (busy_o && t) gn++;
        tick_i = t;
        if (poke && busy_o) begin
          start_i = 1'($urandom % 2);
          vc_i = 4'($urandom); idx_i = 4'($urandom); conc_mode_i = 2'($urandom);
        end
        @(negedge clk_i);
        guard++;
        if (guard > 400) begin
          chk(0, "R5 valid never came", guard, 0);
          done = 1;
        end
      end
    end
    start_i = 1'b0;
    @(negedge clk_i);
    chk(byte_vld_o === 1'b0, "R5 valid one cycle", byte_vld_o, 0);
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(!ale_o && !dle_o && !sao_o, "R10 strobes low", {ale_o, dle_o, sao_o}, 0);
    chk(!busy_o && !err_o && !byte_vld_o, "R10 idle", {busy_o, err_o, byte_vld_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directed
    run_txn(4'd5, 4'd3, 2'd0, 8'hA5, 8'h00, 1, 0);   // R1 R3 R4 R5
    run_txn(4'd11, 4'd8, 2'd0, 8'h3C, 8'h00, 1, 0);  // R1
    run_txn(4'd3, 4'd1, 2'd1, 8'h81, 8'hF0, 1, 0);   // R6
    run_txn(4'd0, 4'd0, 2'd0, 8'h11, 8'h00, 1, 0);   // R7 trace
    run_txn(4'd0, 4'd2, 2'd0, 8'h11, 8'h00, 1, 0);   // R7 label
    run_txn(4'd0, 4'd9, 2'd0, 8'h11, 8'h00, 1, 0);   // R7 undefined code
    run_txn(4'd12, 4'd4, 2'd0, 8'h11, 8'h00, 1, 0);  // R7 VC range
    run_txn(4'd4, 4'd4, 2'd1, 8'h11, 8'h00, 1, 0);   // R8 non-master
    run_txn(4'd9, 4'd4, 2'd1, 8'h77, 8'h00, 1, 0);   // R8 master
    run_txn(4'd3, 4'd5, 2'd2, 8'h11, 8'h00, 1, 0);   // R8 mode 2
    run_txn(4'd0, 4'd5, 2'd2, 8'hFE, 8'h00, 1, 0);   // R8 mode 2 master
    run_txn(4'd0, 4'd5, 2'd3, 8'h11, 8'h00, 1, 0);   // R8 mode 3
    run_txn(4'd6, 4'd6, 2'd0, 8'h5A, 8'h00, 0, 1);   // R9 start while busy, R4 stalls

    // random
    for (int i = 0; i < 300; i++) begin
      run_txn(4'($urandom), 4'($urandom % 10), 2'($urandom), 8'($urandom), 8'($urandom),
              1'($urandom % 2), 1'($urandom % 2));
      if ($urandom % 3 == 0) @(negedge clk_i);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule